// File: doc/BRIEF.md
# Pointer Justification Detector

This block watches the two pointer bytes of every received administrative-unit frame and decides whether the frame carries a positive justification (increment) or a negative one (decrement). A frame strobe marks the cycle in which the two bytes are valid. The block keeps the currently accepted 10-bit pointer. It compares each received pointer against it bit by bit, and a bit that differs counts as inverted. A majority vote over the five odd-position bits (I group) and the five even-position bits (D group) decides the outcome. A mode input selects the rule: a strict 8-of-10 vote or a 3-of-5 group vote.

An optional check compares the two SS bits with a programmed value. A mismatch raises a registered loss-of-pointer alarm, and that frame is not used for justification. Each polarity has its own saturating 11-bit event counter. Software reads a counter through a holding register: a write strobe copies the live count into the holding register and clears the counter in the same cycle. An AIS request toward the downstream path section is raised by a software force, or by the loss-of-pointer alarm when automatic generation is enabled.

Top module: `ptr_just_det`

## Requirements
- R1: After reset, `acc_ptr` is 0, `inc_pulse`, `dec_pulse` and `lop` are 0, and both snapshot outputs are 0.
- R2: The received pointer is `{h1[1:0], h2[7:0]}`. I bits sit at pointer positions 9, 7, 5, 3 and 1, and D bits at 8, 6, 4, 2 and 0. The SS bits are `h1[3:2]`. Frames are evaluated only in cycles where `frame_stb` is 1.
- R3: With `cfg_sonet`=1, let ni and nd be the numbers of differing I and D bits. The frame is an increment when ni+(5-nd) >= 8 and a decrement when nd+(5-ni) >= 8. `inc_pulse` or `dec_pulse` is high for the one cycle after the strobe edge.
- R4: With `cfg_sonet`=0, the frame is an increment when ni >= 3 and nd <= 2, and a decrement when nd >= 3 and ni <= 2.
- R5: An increment sets `acc_ptr` to `acc_ptr`+1, and 782 wraps to 0. A decrement sets it to `acc_ptr`-1, and 0 wraps to 782. A frame equal to the accepted pointer, or one that meets neither rule, leaves `acc_ptr` unchanged and gives no pulse.
- R6: With `cfg_ss_en`=1, a frame whose SS bits differ from `cfg_ss_exp` sets `lop` to 1 and is not used for justification. A matching frame clears `lop`, and with checking disabled `lop` is 0. `lop` changes only on a frame strobe.
- R7: Each event counter is 11 bits wide, adds one per event of its polarity, and holds at 2047.
- R8: `snap_pos_wr` or `snap_neg_wr` copies the live counter into `pos_snap` or `neg_snap` and clears the counter in the same cycle. An event in that same cycle leaves the counter at 1.
- R9: `ais_req` equals `cfg_ais_force | (cfg_ais_auto & lop)`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_stb | input | 1 | Pointer bytes valid this cycle |
| h1 | input | 8 | First pointer byte (SS bits, pointer bits 9:8) |
| h2 | input | 8 | Second pointer byte (pointer bits 7:0) |
| cfg_sonet | input | 1 | 1 selects the 8-of-10 rule, 0 the 3-of-5 rule |
| cfg_ss_en | input | 1 | Enables the SS bit check |
| cfg_ss_exp | input | 2 | Expected SS value |
| cfg_ais_auto | input | 1 | Lets the alarm raise the AIS request |
| cfg_ais_force | input | 1 | Forces the AIS request |
| snap_pos_wr | input | 1 | Snapshot and clear the increment counter |
| snap_neg_wr | input | 1 | Snapshot and clear the decrement counter |
| inc_pulse | output | 1 | Increment detected on the previous strobe |
| dec_pulse | output | 1 | Decrement detected on the previous strobe |
| acc_ptr | output | 10 | Currently accepted pointer |
| lop | output | 1 | Loss-of-pointer alarm |
| ais_req | output | 1 | AIS request to the path section |
| pos_snap | output | 11 | Held increment count |
| neg_snap | output | 11 | Held decrement count |

## Verification
On every cycle, the assertions check that the accepted pointer stays within 0 to 782 and that a pulse follows only a strobe. They also check that increment and decrement never coincide, that each pulse moves the pointer by exactly one step with wrap, and that the pointer and the alarm hold between strobes. A further assertion checks that a saturated counter stays saturated. Whether the majority vote gives the right answer for each pattern of differing bits can only be shown by the bench's scenarios, which sweep all 1024 difference patterns under both rules. The same applies to the counts seen through the snapshot registers, to a strobe and a snapshot in the same cycle, and to the SS check and the AIS paths.

// File: rtl/ptr_just_det.sv
module ptr_just_det #(
  parameter int CNT_W   = 11,
  parameter int PTR_MAX = 782
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_stb,
  input  logic [7:0]       h1,
  input  logic [7:0]       h2,
  input  logic             cfg_sonet,
  input  logic             cfg_ss_en,
  input  logic [1:0]       cfg_ss_exp,
  input  logic             cfg_ais_auto,
  input  logic             cfg_ais_force,
  input  logic             snap_pos_wr,
  input  logic             snap_neg_wr,
  output logic             inc_pulse,
  output logic             dec_pulse,
  output logic [9:0]       acc_ptr,
  output logic             lop,
  output logic             ais_req,
  output logic [CNT_W-1:0] pos_snap,
  output logic [CNT_W-1:0] neg_snap
);
  localparam logic [9:0]       MAXP = 10'(PTR_MAX);
  localparam logic [CNT_W-1:0] SAT  = '1;

  logic [9:0] rx_ptr, diff;
  logic [3:0] n_i, n_d;
  logic       ss_ok, vote_inc, vote_dec, ev_inc, ev_dec;
  logic [CNT_W-1:0] pos_cnt, neg_cnt;

  assign rx_ptr = {h1[1:0], h2};
  assign diff   = rx_ptr ^ acc_ptr;
  assign ss_ok  = !cfg_ss_en || (h1[3:2] == cfg_ss_exp);

  always_comb begin
    n_i = '0;
    n_d = '0;
    for (int k = 0; k < 5; k++) begin
      n_i = n_i + 4'(diff[2*k+1]);
      n_d = n_d + 4'(diff[2*k]);
    end
  end

  assign vote_inc = cfg_sonet ? (n_i >= n_d + 4'd3) : (n_i >= 4'd3 && n_d <= 4'd2);
  assign vote_dec = cfg_sonet ? (n_d >= n_i + 4'd3) : (n_d >= 4'd3 && n_i <= 4'd2);
  assign ev_inc   = frame_stb && ss_ok && vote_inc;
  assign ev_dec   = frame_stb && ss_ok && vote_dec;
  assign ais_req  = cfg_ais_force || (cfg_ais_auto && lop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_ptr   <= '0;
      inc_pulse <= 1'b0;
      dec_pulse <= 1'b0;
      lop       <= 1'b0;
    end else begin
      inc_pulse <= ev_inc;
      dec_pulse <= ev_dec;
      if (ev_inc)
        acc_ptr <= (acc_ptr >= MAXP) ? 10'd0 : acc_ptr + 10'd1;
      else if (ev_dec)
        acc_ptr <= (acc_ptr == 10'd0) ? MAXP : acc_ptr - 10'd1;
      if (frame_stb)
        lop <= cfg_ss_en && (h1[3:2] != cfg_ss_exp);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_cnt  <= '0;
      pos_snap <= '0;
    end else if (snap_pos_wr) begin
      pos_snap <= pos_cnt;
      pos_cnt  <= ev_inc ? CNT_W'(1) : '0;
    end else if (ev_inc && pos_cnt != SAT) begin
      pos_cnt <= pos_cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_cnt  <= '0;
      neg_snap <= '0;
    end else if (snap_neg_wr) begin
      neg_snap <= neg_cnt;
      neg_cnt  <= ev_dec ? CNT_W'(1) : '0;
    end else if (ev_dec && neg_cnt != SAT) begin
      neg_cnt <= neg_cnt + CNT_W'(1);
    end
  end

  a_r5_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ptr <= MAXP);
  a_r3_one_polarity: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_pulse && dec_pulse));
  a_r2_pulse_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    frame_stb == 1'b0 |=> !inc_pulse && !dec_pulse);
  a_r5_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_inc |=> acc_ptr == (($past(acc_ptr) == MAXP) ? 10'd0 : $past(acc_ptr) + 10'd1));
  a_r5_dec_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dec |=> acc_ptr == (($past(acc_ptr) == 10'd0) ? MAXP : $past(acc_ptr) - 10'd1));
  a_r5_hold_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(acc_ptr));
  a_r6_lop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_stb |=> $stable(lop));
  a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_cnt == SAT && !snap_pos_wr) |=> pos_cnt == SAT);
endmodule

// File: tb/tb_ptr_just_det.sv
module tb_ptr_just_det;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_stb = 0, cfg_sonet = 0, cfg_ss_en = 0, cfg_ais_auto = 0, cfg_ais_force = 0;
  logic snap_pos_wr = 0, snap_neg_wr = 0;
  logic [7:0] h1 = 0, h2 = 0;
  logic [1:0] cfg_ss_exp = 0;
  logic inc_pulse, dec_pulse, lop, ais_req;
  logic [9:0] acc_ptr;
  logic [10:0] pos_snap, neg_snap;

  int n_chk = 0, n_bad = 0;
  int m_acc = 0, m_pos = 0, m_neg = 0;

  always #10 clk = ~clk;

  ptr_just_det dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] judge(input logic sonet, input logic [9:0] d);
    int ni = 0, nd = 0;
    logic up, dn;
    for (int k = 0; k < 5; k++) begin
      ni += int'(d[2*k+1]);
      nd += int'(d[2*k]);
    end
    if (sonet) begin
      up = (ni + 5 - nd) >= 8;
      dn = (nd + 5 - ni) >= 8;
    end else begin
      up = ni >= 3 && nd <= 2;
      dn = nd >= 3 && ni <= 2;
    end
    return {up, dn};
  endfunction

  task automatic model(input logic [9:0] rx, input logic ss_pass, input logic wp, input logic wn,
                       output logic ei, output logic ed);
    logic [1:0] j;
    j = ss_pass ? judge(cfg_sonet, rx ^ 10'(m_acc)) : 2'b00;
    ei = j[1];
    ed = j[0];
    if (ei) m_acc = (m_acc == 782) ? 0 : m_acc + 1;
    else if (ed) m_acc = (m_acc == 0) ? 782 : m_acc - 1;
    if (wp) m_pos = int'(ei);
    else if (ei && m_pos < 2047) m_pos++;
    if (wn) m_neg = int'(ed);
    else if (ed && m_neg < 2047) m_neg++;
  endtask

  task automatic send(input logic [1:0] ss, input logic [9:0] rx, input logic wp, input logic wn,
                      output logic ei, output logic ed);
    @(negedge clk);
    h1 = {4'b0000, ss, rx[9:8]};
    h2 = rx[7:0];
    frame_stb = 1'b1;
    snap_pos_wr = wp;
    snap_neg_wr = wn;
    model(rx, !cfg_ss_en || ss == cfg_ss_exp, wp, wn, ei, ed);
    @(negedge clk);
    frame_stb = 1'b0;
    snap_pos_wr = 1'b0;
    snap_neg_wr = 1'b0;
  endtask

  task automatic snap_both();
    @(negedge clk);
    snap_pos_wr = 1'b1;
    snap_neg_wr = 1'b1;
    @(negedge clk);
    snap_pos_wr = 1'b0;
    snap_neg_wr = 1'b0;
  endtask

  initial begin
    logic ei, ed;
    logic [10:0] keep;
    repeat (3) @(negedge clk);
    chk("R1 acc_ptr", int'(acc_ptr), 0);
    chk("R1 pulses", int'(inc_pulse) + int'(dec_pulse), 0);
    chk("R1 lop", int'(lop), 0);
    chk("R1 snaps", int'(pos_snap) + int'(neg_snap), 0);
    rst_n = 1'b1;

    for (int mode = 1; mode >= 0; mode--) begin
      cfg_sonet = mode[0];
      for (int d = 0; d < 1024; d++) begin
        send(2'b01, 10'(m_acc) ^ 10'(d), 1'b0, 1'b0, ei, ed);
        chk(mode ? "R3 inc_pulse" : "R4 inc_pulse", int'(inc_pulse), int'(ei));
        chk(mode ? "R3 dec_pulse" : "R4 dec_pulse", int'(dec_pulse), int'(ed));
        chk("R5 acc_ptr", int'(acc_ptr), m_acc);
      end
    end
    snap_both();
    chk("R7 pos count", int'(pos_snap), m_pos);
    chk("R7 neg count", int'(neg_snap), m_neg);
    m_pos = 0;
    m_neg = 0;

    cfg_sonet = 1'b1;
    for (int n = 0; n < 2100; n++) send(2'b00, 10'(m_acc) ^ 10'h2AA, 1'b0, 1'b0, ei, ed);
    snap_both();
    chk("R7 saturate at 2047", int'(pos_snap), 2047);
    chk("R7 neg untouched", int'(neg_snap), 0);
    m_pos = 0;
    m_neg = 0;

    send(2'b00, 10'(m_acc) ^ 10'h2AA, 1'b1, 1'b0, ei, ed);
    chk("R8 snapshot before event", int'(pos_snap), 0);
    snap_both();
    chk("R8 same-cycle event kept", int'(pos_snap), 1);
    m_pos = 0;
    m_neg = 0;

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_acc = 0;
    chk("R1 acc after reset", int'(acc_ptr), 0);
    send(2'b00, 10'h155, 1'b0, 1'b0, ei, ed);
    chk("R5 wrap 0 to 782", int'(acc_ptr), 782);
    chk("R3 dec pulse at wrap", int'(dec_pulse), 1);
    send(2'b00, 10'd782 ^ 10'h2AA, 1'b0, 1'b0, ei, ed);
    chk("R5 wrap 782 to 0", int'(acc_ptr), 0);
    send(2'b00, 10'd0, 1'b0, 1'b0, ei, ed);
    chk("R5 equal pointer no pulse", int'(inc_pulse) + int'(dec_pulse), 0);
    chk("R5 equal pointer unchanged", int'(acc_ptr), 0);

    cfg_ss_en = 1'b1;
    cfg_ss_exp = 2'b10;
    send(2'b10, 10'h2AA, 1'b0, 1'b0, ei, ed);
    chk("R6 ss match inc", int'(inc_pulse), 1);
    chk("R6 ss match lop", int'(lop), 0);
    keep = 11'(acc_ptr);
    send(2'b01, acc_ptr ^ 10'h2AA, 1'b0, 1'b0, ei, ed);
    chk("R6 ss mismatch lop", int'(lop), 1);
    chk("R6 ss mismatch no pulse", int'(inc_pulse), 0);
    chk("R6 ss mismatch ptr kept", int'(acc_ptr), int'(keep));
    repeat (3) @(negedge clk);
    chk("R6 lop held without strobe", int'(lop), 1);
    chk("R9 auto off", int'(ais_req), 0);
    cfg_ais_auto = 1'b1;
    #1 chk("R9 auto with lop", int'(ais_req), 1);
    send(2'b10, 10'(m_acc), 1'b0, 1'b0, ei, ed);
    chk("R6 match clears lop", int'(lop), 0);
    chk("R9 auto without lop", int'(ais_req), 0);
    cfg_ais_force = 1'b1;
    #1 chk("R9 force", int'(ais_req), 1);
    cfg_ais_auto = 1'b0;
    #1 chk("R9 force without auto", int'(ais_req), 1);
    cfg_ais_force = 1'b0;
    cfg_ss_en = 1'b0;
    send(2'b01, 10'(m_acc), 1'b0, 1'b0, ei, ed);
    chk("R6 disabled lop", int'(lop), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule